// File: doc/BRIEF.md
# Reference-Sweep Conversion Sequencer

This controller runs the digital side of a single-slope conversion for one analog dot-product column. On a start strobe it captures a 16-bit vector of 1-bit activations and drives it onto the column's word lines. It then steps an external threshold through sixteen rising levels. Each level is set by two controls: a thermometer mask that enables some of eight reference rows, and a drain-bias select bit. In every sensing cycle it reads a one-bit comparator. It then pulses the comparator reset so that the next cycle starts clean.

The threshold sweep has two halves. In the lower half the bias select is low and the enabled row count falls from eight to one. In the upper half the bias select is high and the row count climbs from one back to eight. The threshold rises in every cycle even though the row count does not. The output code is the number of cycles in which the comparator fired, saturated to four bits. A binary-activation mode runs a single sensing cycle and yields a 1-bit result.

Top module: `refsweep_conv_seq`

## Requirements
- R1: A start strobe accepted in idle latches `wl_in_i` onto `wl_drive_o` on that clock edge. The vector holds unchanged until the next accepted start or reset.
- R2: A full conversion has 16 sensing cycles, each lasting three clocks: settle, sample and comparator reset. If start is sampled at edge 0, `done_o` is high after edge 49.
- R3: `ref_en_o` is a thermometer mask: bit i is high exactly when i is below the active row count. The mask is all zero outside sensing cycles.
- R4: In cycles 1 to 8 `bias_sel_o` is low and the row count is 9 minus the cycle number. In cycles 9 to 16 `bias_sel_o` is high and the row count is the cycle number minus 8. The threshold level, computed as 9 minus the count with bias low or 8 plus the count with bias high, is therefore equal to the cycle number.
- R5: `cmp_fire_i` is sampled at the edge that ends the sample phase. `cmp_rst_o` is high for exactly the one clock that follows each sample phase.
- R6: `code_o` is cleared on an accepted start. It counts the cycles in which the comparator fired and saturates at 15. It holds after done until the next start.
- R7: `done_o` is a single-clock pulse at the end of each conversion.
- R8: With `bin_mode_i` high at start, the block runs one sensing cycle at level 9 (bias high, one row). `code_o` is then 1 if the comparator fired and 0 otherwise, and `done_o` is high after edge 4.
- R9: A start strobe that arrives while the block is not idle, including the done clock, is ignored. It does not change the code, the word lines or the timing.
- R10: Synchronous reset returns the block to idle. The mask, bias select, comparator reset, done flag, code and word-line drive are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| bin_mode_i | input | 1 | Binary-activation mode select, sampled at start |
| wl_in_i | input | 16 | 1-bit activation vector |
| cmp_fire_i | input | 1 | Comparator result |
| wl_drive_o | output | 16 | Word-line drive, held for the conversion |
| ref_en_o | output | 8 | Reference-row enable mask |
| bias_sel_o | output | 1 | Drain-bias select |
| cmp_rst_o | output | 1 | Comparator reset pulse |
| code_o | output | 4 | Output code |
| done_o | output | 1 | Conversion-complete pulse |

## Verification
Two events can coincide. A new start strobe can land in the same cycle as a comparator sample, which would clear or restart the counter while it is accumulating. The final sample of the sixteenth cycle can also coincide with saturation of the code at 15. The bench injects a start with a complemented vector partway through a conversion, on a clock where a sample is in progress. It then judges that the code, the word-line drive and the done timing all match a run without the strobe. It drives a full vector so that the comparator fires in all sixteen cycles, and expects the code to stop at 15 rather than wrap to 0.

// File: rtl/refsweep_pkg.sv
package refsweep_pkg;

    parameter int N_WL   = 16;
    parameter int N_REF  = 8;
    parameter int CODE_W = 4;

    localparam int N_LVL   = 2 * N_REF;
    localparam int IDX_W   = $clog2(N_LVL);
    localparam int CNT_W   = $clog2(N_REF + 1);
    localparam int BIN_IDX = N_REF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_SETTLE,
        ST_SAMPLE,
        ST_CLEAR,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [CNT_W-1:0] rows;
        logic             bias;
    } ref_pt_t;

    function automatic ref_pt_t level_point(input logic [IDX_W-1:0] idx);
        ref_pt_t p;
        if (int'(idx) < N_REF) begin
            p.rows = CNT_W'(N_REF - int'(idx));
            p.bias = 1'b0;
        end else begin
            p.rows = CNT_W'(int'(idx) - N_REF + 1);
            p.bias = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
    import refsweep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bin_mode_i,
    output st_e              state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             accept_o
);

    st_e              state_q;
    logic [IDX_W-1:0] idx_q;
    logic             bin_q;

    assign accept_o = start_i && (state_q == ST_IDLE);
    assign state_o  = state_q;
    assign idx_o    = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            bin_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_APPLY;
                        bin_q   <= bin_mode_i;
                        idx_q   <= bin_mode_i ? IDX_W'(BIN_IDX) : '0;
                    end
                end
                ST_APPLY:  state_q <= ST_SETTLE;
                ST_SETTLE: state_q <= ST_SAMPLE;
                ST_SAMPLE: state_q <= ST_CLEAR;
                ST_CLEAR: begin
                    if (bin_q || (idx_q == IDX_W'(N_LVL - 1))) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_DONE:   state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bin_q && state_q == ST_CLEAR) |=> (state_q == ST_DONE)); // R8

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR && $past(state_q) == ST_SAMPLE) |=>
            (state_q == ST_DONE || idx_q == $past(idx_q) + 1'b1)); // R2

endmodule

// File: rtl/rs_ref_drive.sv
module rs_ref_drive
    import refsweep_pkg::*;
(
    input  logic             active_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N_REF-1:0] ref_en_o,
    output logic             bias_o
);

    ref_pt_t pt;

    always_comb begin
        pt = level_point(idx_i);
    end

    for (genvar i = 0; i < N_REF; i++) begin : g_row
        assign ref_en_o[i] = active_i && (pt.rows > CNT_W'(i));
    end

    assign bias_o = active_i && pt.bias;

    always_comb begin
        AST_MASK_THERMO: assert (((ref_en_o + 1'b1) & ref_en_o) == '0); // R3
    end

endmodule

// File: rtl/rs_code_acc.sv
module rs_code_acc
    import refsweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              fire_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            code_q <= '0;
        end else if (sample_i && fire_i && (code_q != '1)) begin
            code_q <= code_q + 1'b1;
        end
    end

    assign code_o = code_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (code_o >= $past(code_o))); // R6

endmodule

// File: rtl/refsweep_conv_seq.sv
module refsweep_conv_seq
    import refsweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bin_mode_i,
    input  logic [N_WL-1:0]   wl_in_i,
    input  logic              cmp_fire_i,
    output logic [N_WL-1:0]   wl_drive_o,
    output logic [N_REF-1:0]  ref_en_o,
    output logic              bias_sel_o,
    output logic              cmp_rst_o,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);

    st_e              fsm_state;
    logic [IDX_W-1:0] fsm_idx;
    logic             accept;
    logic [N_WL-1:0]  wl_q;
    logic             sensing;

    rs_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bin_mode_i (bin_mode_i),
        .state_o    (fsm_state),
        .idx_o      (fsm_idx),
        .accept_o   (accept)
    );

    assign sensing = (fsm_state == ST_SETTLE) || (fsm_state == ST_SAMPLE) ||
                     (fsm_state == ST_CLEAR);

    rs_ref_drive u_ref (
        .active_i (sensing),
        .idx_i    (fsm_idx),
        .ref_en_o (ref_en_o),
        .bias_o   (bias_sel_o)
    );

    rs_code_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (accept),
        .sample_i (fsm_state == ST_SAMPLE),
        .fire_i   (cmp_fire_i),
        .code_o   (code_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wl_q <= '0;
        end else if (accept) begin
            wl_q <= wl_in_i;
        end
    end

    assign wl_drive_o = wl_q;
    assign cmp_rst_o  = (fsm_state == ST_CLEAR);
    assign done_o     = (fsm_state == ST_DONE);

    AST_WL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fsm_state != ST_IDLE) |=> $stable(wl_drive_o)); // R1

    AST_RST_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_SAMPLE) |=> cmp_rst_o); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_BIAS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bias_sel_o && !cmp_rst_o) |=> bias_sel_o); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && fsm_state == ST_SAMPLE) |=> (fsm_state == ST_CLEAR)); // R9

endmodule

// File: tb/refsweep_conv_seq_tb.sv
module refsweep_conv_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bin_mode = 1'b0;
    logic [15:0] wl_in = '0;
    logic        cmp_fire;
    logic [15:0] wl_drive;
    logic [7:0]  ref_en;
    logic        bias_sel;
    logic        cmp_rst;
    logic [3:0]  code;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    refsweep_conv_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .bin_mode_i (bin_mode),
        .wl_in_i    (wl_in),
        .cmp_fire_i (cmp_fire),
        .wl_drive_o (wl_drive),
        .ref_en_o   (ref_en),
        .bias_sel_o (bias_sel),
        .cmp_rst_o  (cmp_rst),
        .code_o     (code),
        .done_o     (done)
    );

    function automatic int lvl_of(input logic [7:0] m, input logic b);
        int c = $countones(m);
        return b ? 8 + c : 9 - c;
    endfunction

    // behavioural comparator: strength = number of active word lines
    assign cmp_fire = (ref_en != '0) && ($countones(wl_drive) >= lvl_of(ref_en, bias_sel));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic t_reset_state();
        @(negedge clk);
        check(ref_en == 0 && !bias_sel && !cmp_rst && !done, "R10 outputs", {ref_en, bias_sel, cmp_rst, done}, 0);
        check(code == 0 && wl_drive == 0, "R10 code/wl", {code, wl_drive}, 0);
    endtask

    task automatic t_conv(input logic [15:0] vec, input bit bin, input bit inject);
        int exp_code, exp_done, pulses, done_at, ones, dones;
        bit lvl_ok, mask_ok, bias_ok;
        ones = $countones(vec);
        exp_code = bin ? (ones >= 9 ? 1 : 0) : (ones > 15 ? 15 : ones);
        exp_done = bin ? 4 : 49;
        pulses = 0; done_at = -1; dones = 0;
        lvl_ok = 1; mask_ok = 1; bias_ok = 1;
        @(negedge clk); start = 1; bin_mode = bin; wl_in = vec;
        @(negedge clk); start = 0;
        check(wl_drive == vec, "R1 latch", wl_drive, vec);
        check(ref_en == 0 && code == 0, "R3 mask idle at apply", ref_en, 0);
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (inject && n == 20) begin start = 1; wl_in = ~vec; end
            if (inject && n == 21) start = 0;
            if (ref_en != 0) begin
                if (((ref_en + 8'd1) & ref_en) != 0) mask_ok = 0;
                if (lvl_of(ref_en, bias_sel) != (bin ? 9 : pulses + 1)) lvl_ok = 0;
                if (bias_sel != (bin ? 1'b1 : (pulses >= 8))) bias_ok = 0;
            end
            if (cmp_rst) pulses++;
            if (done) begin dones++; if (done_at < 0) done_at = n; end
            if (wl_drive != vec) check(0, "R1 hold", wl_drive, vec);
        end
        check(mask_ok, "R3 thermometer", 0, 1);
        check(lvl_ok, "R4 level sequence", 0, 1);
        check(bias_ok, "R4 bias halves", 0, 1);
        check(pulses == (bin ? 1 : 16), "R5 reset pulses", pulses, bin ? 1 : 16);
        check(done_at == exp_done, bin ? "R8 done time" : "R2 done time", done_at, exp_done);
        check(dones == 1, "R7 single done", dones, 1);
        check(code == exp_code, bin ? "R8 code" : (inject ? "R9 code" : "R6 code"), code, exp_code);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); start = 1; bin_mode = 0; wl_in = 16'h0FF0;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        rst = 1;
        @(negedge clk); rst = 0;
        check(ref_en == 0 && !bias_sel && !cmp_rst && !done, "R10 mid reset outs", ref_en, 0);
        check(code == 0 && wl_drive == 0, "R10 mid reset code", code, 0);
        repeat (60) @(negedge clk);
        check(!done && ref_en == 0, "R10 stays idle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        t_conv(16'h0000, 0, 0);
        t_conv(16'h8421 | 16'h0100, 0, 0);
        t_conv(16'h7FFF, 0, 0);
        t_conv(16'hFFFF, 0, 0);      // saturation R6
        repeat (5) @(negedge clk);
        check(code == 15, "R6 held after done", code, 15);
        t_conv(16'h00FF, 1, 0);      // binary, 8 ones -> 0
        t_conv(16'h0FFF, 1, 0);      // binary, 12 ones -> 1
        t_conv(16'h03F0, 0, 1);      // R9 injected start
        t_reset_mid();
        t_conv(16'hAAAA, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule